// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a host read serial flash as if it were ordinary memory. A host read names a chip select and an offset inside the flash window. The engine turns that read into a complete serial read sequence on that chip select:

- It lowers the chip select.
- It clocks out a read opcode and the address.
- It idles through any dummy bytes.
- It shifts in one data word on one, two or four lines.
- It releases the chip select and hands the word back.

The host request stays pending, with ready low, until the word is assembled. Software picks the opcode, address length, dummy length and line mode separately for each chip select, through a small write-only setup port. A mode bit turns the whole window on or off. While the window is off, the register-command path owns the flash pins, so host reads complete at once with zero data.

The serial clock runs at half the core clock and idles low. Outgoing bits change while the clock is low, and incoming bits are taken on the rising edge.

Top module: `mmap_flash_reader`

## Requirements
- R1: After reset every chip select output is high, the serial clock is low and host ready is low.
- R2: A setup word for chip select n is written at offset 0x54+4n. Its fields are: bits 7:0 opcode; bits 9:8 address bytes minus one; bits 11:10 dummy byte count; bits 13:12 data line code. Bit 0 of a write at offset 0x64 sets the mapped-mode enable. After reset every setup word holds opcode 0x03, three address bytes, no dummy bytes and single-line data, and mapped mode is off.
- R3: A host read made while mapped mode is off returns ready on the first clock edge after the request, with zero data and no chip select ever low.
- R4: In the command phase the opcode and then the address bytes go out most significant bit first on io line 0, one bit per serial clock, with only io line 0 driven. The address bytes are the low bytes of the window offset, zero-extended.
- R5: Each dummy byte lasts eight serial clocks, whatever the data line mode. During the dummy and data phases no io line is driven. A whole access uses exactly 8+8*A+8*D+32/L rising serial clock edges.
- R6: The data phase takes in 32 bits. Line code 1 reads two lines (io1 is the more significant bit). Code 3 reads four lines (io3 most significant). Codes 0 and 2 read one bit per clock from io1. Incoming bits are sampled only on rising serial clock edges.
- R7: Within each byte the first received bit is the most significant. The first received byte lands in bits 7:0 of the returned word, and later bytes fill the higher lanes in order.
- R8: The serial clock stays low while no chip select is active. Driven io lines change only while the serial clock is low.
- R9: Only the chip select named by the request goes low during an access, and it goes high before ready. Ready is high for exactly one cycle per request.
- R10: A setup write that arrives during an access does not affect that access. It takes effect from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup-port write strobe |
| cfg_addr | input | 8 | Setup-port byte offset |
| cfg_wdata | input | 14 | Setup-port write data |
| hst_req | input | 1 | Host read request, held until ready |
| hst_sel | input | SEL_W | Chip select addressed by the read |
| hst_addr | input | AW | Offset in the window (equals the flash address) |
| hst_ready | output | 1 | One-cycle completion strobe |
| hst_rdata | output | DW | Returned data word |
| fl_sclk | output | 1 | Serial clock |
| fl_cs_n | output | NCS | Active-low chip selects |
| fl_io_out | output | 4 | Outgoing io line values |
| fl_io_oe | output | 4 | io line output enables |
| fl_io_in | input | 4 | Incoming io line values |

## Verification
A corrupt bit or phase counter shows at the pins within one access. The bench counts rising serial clock edges per access, so it sees a wrong total at the ready strobe. A wrong transmit shift or a wrong address alignment shows up as wrong command bits, which the flash model captures on each rising edge. A wrong lane width or sample point scrambles the returned word in a pattern that depends on the address. A setup word latched at the wrong moment changes the opcode seen in the same access.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DUMMY,
      ST_DATA,
      ST_DONE
   } mfr_state_e;

   typedef struct packed {
      logic [1:0] rmode;
      logic [1:0] dummy;
      logic [1:0] abytes_m1;
      logic [7:0] opcode;
   } setup_t;

   localparam logic [7:0] SETUP_BASE = 8'h54;
   localparam logic [7:0] SWITCH_OFS = 8'h64;

   function automatic logic [1:0] lanes_log2(input logic [1:0] code);
      case (code)
         2'd1:    return 2'd1;
         2'd3:    return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/mfr_regs.sv
module mfr_regs
   import mfr_pkg::*;
#(
   parameter int NCS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [7:0]            cfg_addr,
   input  logic [$bits(setup_t)-1:0] cfg_wdata,
   output logic                  mm_en,
   output setup_t [NCS-1:0]      setups
);

   localparam setup_t SETUP_RST = '{rmode: 2'd0, dummy: 2'd0, abytes_m1: 2'd2, opcode: 8'h03};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mm_en <= 1'b0;
      else if (cfg_we && cfg_addr == SWITCH_OFS)
         mm_en <= cfg_wdata[0];
   end

   for (genvar i = 0; i < NCS; i++) begin : g_setup
      localparam logic [7:0] OFS = SETUP_BASE + 8'(4 * i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            setups[i] <= SETUP_RST;
         else if (cfg_we && cfg_addr == OFS)
            setups[i] <= setup_t'(cfg_wdata);
      end
   end

endmodule

// File: rtl/mfr_rxpack.sv
module mfr_rxpack #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_en,
   input  logic [1:0]    lw,
   input  logic [3:0]    io_in,
   output logic [DW-1:0] rdata
);

   localparam int NBYTES = DW / 8;

   logic [DW-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (clr)
         sr <= '0;
      else if (smp_en) begin
         case (lw)
            2'd0:    sr <= {sr[DW-2:0], io_in[1]};
            2'd1:    sr <= {sr[DW-3:0], io_in[1:0]};
            default: sr <= {sr[DW-5:0], io_in};
         endcase
      end
   end

   // first byte in the stream sits at the top of sr; move it to lane 0
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign rdata[8*b +: 8] = sr[DW-1-8*b -: 8];
   end

endmodule

// File: rtl/mfr_seq.sv
module mfr_seq
   import mfr_pkg::*;
#(
   parameter int NCS   = 4,
   parameter int AW    = 24,
   parameter int DW    = 32,
   parameter int SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [SEL_W-1:0]  sel,
   input  logic [AW-1:0]     addr,
   input  logic              mm_en,
   input  setup_t [NCS-1:0]  setups,
   output logic [NCS-1:0]    cs_n,
   output logic              sclk,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   output logic              smp_en,
   output logic              clr,
   output logic [1:0]        lw,
   output logic              ready
);

   localparam int CNT_W = $clog2(DW + 41);
   localparam int TX_W  = 40;

   mfr_state_e        st;
   logic              ph;
   logic [CNT_W-1:0]  cnt;
   logic [TX_W-1:0]   tx_sr;
   logic [1:0]        dum_q;
   logic [1:0]        lw_q;
   logic [SEL_W-1:0]  sel_q;
   setup_t            nxt_cfg;
   logic [31:0]       a_al;
   logic              active;
   logic [CNT_W-1:0]  data_ticks;

   always_comb begin
      nxt_cfg = setups[sel];
      a_al    = 32'(addr) << (8 * (3 - int'(nxt_cfg.abytes_m1)));
   end

   assign data_ticks = CNT_W'((DW >> lw_q) - 1);
   assign active     = (st == ST_CMD) || (st == ST_DUMMY) || (st == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         ph    <= 1'b0;
         cnt   <= '0;
         tx_sr <= '0;
         dum_q <= '0;
         lw_q  <= '0;
         sel_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req) begin
                  if (mm_en) begin
                     tx_sr <= {nxt_cfg.opcode, a_al};
                     dum_q <= nxt_cfg.dummy;
                     lw_q  <= lanes_log2(nxt_cfg.rmode);
                     sel_q <= sel;
                     cnt   <= CNT_W'(8 * int'(nxt_cfg.abytes_m1) + 15);
                     ph    <= 1'b0;
                     st    <= ST_CMD;
                  end else begin
                     st <= ST_DONE;
                  end
               end
            end
            ST_CMD, ST_DUMMY, ST_DATA: begin
               if (!ph) begin
                  ph <= 1'b1;
               end else begin
                  ph <= 1'b0;
                  if (st == ST_CMD)
                     tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else begin
                     case (st)
                        ST_CMD: begin
                           if (dum_q != 2'd0) begin
                              st  <= ST_DUMMY;
                              cnt <= CNT_W'(8 * int'(dum_q) - 1);
                           end else begin
                              st  <= ST_DATA;
                              cnt <= data_ticks;
                           end
                        end
                        ST_DUMMY: begin
                           st  <= ST_DATA;
                           cnt <= data_ticks;
                        end
                        default: st <= ST_DONE;
                     endcase
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cs_n   = active ? ~(NCS'(1) << sel_q) : '1;
   assign sclk   = ph;
   assign io_out = {3'b000, tx_sr[TX_W-1]};
   assign io_oe  = {3'b000, st == ST_CMD};
   assign smp_en = (st == ST_DATA) && !ph;
   assign clr    = (st == ST_IDLE) && req;
   assign lw     = lw_q;
   assign ready  = (st == ST_DONE);

   p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   p_sclk_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk);

   p_drive_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(io_out));

   p_off_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req && !mm_en) |=> (ready && (&cs_n)));

   p_sample_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |=> sclk);

endmodule

// File: rtl/mmap_flash_reader.sv
module mmap_flash_reader
   import mfr_pkg::*;
#(
   parameter  int NCS   = 4,
   parameter  int AW    = 24,
   parameter  int DW    = 32,
   localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [7:0]       cfg_addr,
   input  logic [13:0]      cfg_wdata,
   input  logic             hst_req,
   input  logic [SEL_W-1:0] hst_sel,
   input  logic [AW-1:0]    hst_addr,
   output logic             hst_ready,
   output logic [DW-1:0]    hst_rdata,
   output logic             fl_sclk,
   output logic [NCS-1:0]   fl_cs_n,
   output logic [3:0]       fl_io_out,
   output logic [3:0]       fl_io_oe,
   input  logic [3:0]       fl_io_in
);

   if (NCS < 1 || NCS > 4) begin : g_bad_ncs
      $error("NCS must lie in 1..4 so setup words stay below the switch offset");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 8..32");
   end
   if (DW < 8 || DW % 8 != 0) begin : g_bad_dw
      $error("DW must be a positive multiple of 8");
   end

   logic             mm_en;
   setup_t [NCS-1:0] setups;
   logic             smp_en;
   logic             clr;
   logic [1:0]       lw;

   mfr_regs #(.NCS(NCS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .mm_en     (mm_en),
      .setups    (setups)
   );

   mfr_seq #(.NCS(NCS), .AW(AW), .DW(DW), .SEL_W(SEL_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (hst_req),
      .sel    (hst_sel),
      .addr   (hst_addr),
      .mm_en  (mm_en),
      .setups (setups),
      .cs_n   (fl_cs_n),
      .sclk   (fl_sclk),
      .io_out (fl_io_out),
      .io_oe  (fl_io_oe),
      .smp_en (smp_en),
      .clr    (clr),
      .lw     (lw),
      .ready  (hst_ready)
   );

   mfr_rxpack #(.DW(DW)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .smp_en (smp_en),
      .lw     (lw),
      .io_in  (fl_io_in),
      .rdata  (hst_rdata)
   );

endmodule

// File: tb/sim_mmap_flash_reader.sv
`timescale 1ns/1ps
module sim_mmap_flash_reader;

   localparam int NCS = 4;
   localparam int AW  = 24;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_addr = '0;
   logic [13:0]   cfg_wdata = '0;
   logic          hst_req = 1'b0;
   logic [1:0]    hst_sel = '0;
   logic [AW-1:0] hst_addr = '0;
   logic          hst_ready;
   logic [DW-1:0] hst_rdata;
   logic          fl_sclk;
   logic [3:0]    fl_cs_n;
   logic [3:0]    fl_io_out;
   logic [3:0]    fl_io_oe;
   logic [3:0]    fl_io_in = '0;

   always #2 clk = ~clk;

   mmap_flash_reader #(.NCS(NCS), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .hst_req(hst_req), .hst_sel(hst_sel),
      .hst_addr(hst_addr), .hst_ready(hst_ready), .hst_rdata(hst_rdata),
      .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out),
      .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // bench mirror of the setup words
   logic [7:0] b_op[NCS];
   int         b_ab[NCS];
   int         b_dum[NCS];
   int         b_lw[NCS];
   bit         b_mm = 1'b0;

   // flash model state
   int          m_ncmd = 0;
   int          m_ndum = 0;
   int          m_lw = 0;
   logic [31:0] m_stream = '0;
   int          rises = 0;
   logic [63:0] cap = '0;
   logic [3:0]  cs_low = '0;
   int          oe_bad = 0;
   logic        prev_sclk = 1'b0;

   typedef struct {
      logic [31:0] rdata;
      logic [63:0] cmd;
      int          ncmd;
      int          nrise;
      logic [3:0]  cs;
      string       tag;
   } exp_t;
   exp_t q[$];

   // flash model and scoreboard monitor
   always @(negedge clk) begin
      if (!(&fl_cs_n)) cs_low |= ~fl_cs_n;
      if (fl_sclk && !prev_sclk) begin
         rises++;
         if (rises <= m_ncmd) begin
            cap = {cap[62:0], fl_io_out[0]};
            if (fl_io_oe != 4'b0001) oe_bad++;
         end else if (fl_io_oe != 4'b0000) begin
            oe_bad++;
         end
      end
      if (!fl_sclk && prev_sclk && rises >= m_ncmd + m_ndum) begin
         int k, nl, lo;
         k  = rises - (m_ncmd + m_ndum);
         nl = 1 << m_lw;
         if (k * nl < 32) begin
            lo = 32 - (k + 1) * nl;
            fl_io_in = '0;
            for (int j = 0; j < nl; j++)
               fl_io_in[(nl == 1) ? 1 : j] = m_stream[lo + j];
         end
      end
      prev_sclk = fl_sclk;
      if (hst_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9", "ready without request", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(hst_rdata == e.rdata, e.tag, "data word R6/R7", hst_rdata, e.rdata);
            if (e.ncmd > 0)
               chk((cap & ((64'd1 << e.ncmd) - 1)) == e.cmd, "R4", "command bits",
                   cap & ((64'd1 << e.ncmd) - 1), e.cmd);
            chk(rises == e.nrise, "R5", "rising sclk count", rises, e.nrise);
            chk(oe_bad == 0, "R5", "io enable misuse", oe_bad, 0);
            chk(cs_low == e.cs, "R9", "chip selects seen low", cs_low, e.cs);
            chk(&fl_cs_n && !fl_sclk, "R8", "pins parked at ready",
                {fl_cs_n, fl_sclk}, 5'h1E);
         end
      end
   end

   task automatic cfg_write(input logic [7:0] a, input logic [13:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_setup(input int cs, input logic [7:0] op, input int ab,
                            input int dum, input logic [1:0] code);
      cfg_write(8'h54 + 8'(4 * cs), {code, 2'(dum), 2'(ab - 1), op});
      b_op[cs]  = op;
      b_ab[cs]  = ab;
      b_dum[cs] = dum;
      b_lw[cs]  = (code == 2'd1) ? 1 : (code == 2'd3) ? 2 : 0;
   endtask

   task automatic do_read(input int cs, input logic [AW-1:0] a, input string tag,
                          input bit midwrite);
      exp_t e;
      logic [7:0] b[4];
      int w;
      for (int i = 0; i < 4; i++)
         b[i] = a[7:0] ^ 8'(8'h21 * (i + 1)) ^ a[15:8];
      m_stream = {b[0], b[1], b[2], b[3]};
      e.tag = tag;
      if (b_mm) begin
         m_ncmd  = 8 + 8 * b_ab[cs];
         m_ndum  = 8 * b_dum[cs];
         m_lw    = b_lw[cs];
         e.rdata = {b[3], b[2], b[1], b[0]};
         e.ncmd  = m_ncmd;
         e.cmd   = (64'(b_op[cs]) << (8 * b_ab[cs])) |
                   (64'(a) & ((64'd1 << (8 * b_ab[cs])) - 1));
         e.nrise = m_ncmd + m_ndum + (32 >> m_lw);
         e.cs    = 4'(1 << cs);
      end else begin
         m_ncmd = 0; m_ndum = 0; m_lw = 0;
         e.rdata = '0; e.ncmd = 0; e.cmd = '0; e.nrise = 0; e.cs = '0;
      end
      rises = 0; cap = '0; cs_low = '0; oe_bad = 0;
      q.push_back(e);
      if (midwrite) begin
         fork
            begin
               repeat (4) @(negedge clk);
               set_setup(cs, 8'hFF, 1, 0, 2'd3);
            end
         join_none
      end
      @(negedge clk);
      hst_sel = 2'(cs); hst_addr = a; hst_req = 1'b1;
      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!hst_ready && w < 5000);
      hst_req = 1'b0;
      if (!b_mm) chk(w == 1, "R3", "off-mode ready latency", w, 1);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCS; i++) begin
         b_op[i] = 8'h03; b_ab[i] = 3; b_dum[i] = 0; b_lw[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk(&fl_cs_n, "R1", "cs_n in reset", fl_cs_n, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(&fl_cs_n, "R1", "cs_n after reset", fl_cs_n, 4'hF);
      chk(!fl_sclk, "R1", "sclk after reset", fl_sclk, 0);
      chk(!hst_ready, "R1", "ready after reset", hst_ready, 0);

      // window off after reset
      do_read(2, 24'h00ABCD, "R3", 1'b0);
      cfg_write(8'h64, 14'h1); b_mm = 1'b1;
      // reset defaults
      do_read(3, 24'h123456, "R2", 1'b0);
      set_setup(0, 8'h0B, 3, 1, 2'd0);
      do_read(0, 24'h345678, "R5", 1'b0);
      set_setup(2, 8'h6B, 4, 1, 2'd3);
      do_read(2, 24'hC0FFEE, "R6", 1'b0);
      set_setup(1, 8'hBB, 1, 3, 2'd1);
      do_read(1, 24'h00005A, "R6", 1'b0);
      set_setup(0, 8'h3B, 2, 2, 2'd2);
      do_read(0, 24'h9ABCDE, "R6", 1'b0);
      do_read(2, 24'h010203, "R7", 1'b0);
      // setup rewritten mid-access
      do_read(2, 24'h4455AA, "R10", 1'b1);
      do_read(2, 24'h7788EE, "R10", 1'b0);
      // switch off again
      cfg_write(8'h64, 14'h0); b_mm = 1'b0;
      do_read(1, 24'h111111, "R3", 1'b0);
      cfg_write(8'h64, 14'h3); b_mm = 1'b1;
      do_read(1, 24'h222222, "R2", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule